// File: doc/BRIEF.md
# Three-Table Configurable Logic Tile

This tile is one logic cell of a programmable fabric. Two 4-input lookup tables, F and G, each hold a 16-bit truth table. A third, 3-input table, H, holds 8 bits. Each of H's first two inputs comes either from one of the 4-input tables or from a direct tile input. Its third input is always a direct input. Because of this, a single tile can hold any two 4-input functions together with a 3-input function, or any 5-input function. It can also hold some 9-input functions, such as 9-bit parity or one stage of a cascaded 4-bit equality compare.

The tile has two outputs, X and Y. Each has a flip-flop that captures F, G or H, and a bit that chooses between the registered value and the combinational value. All truth tables and selection bits sit in one serial configuration chain. The chain is filled at initialization while the load enable is high. Its far end is available as an output, so tiles can be chained and the contents read back.

Top module: `logic_tile`

## Requirements
- R1: A synchronous active-low reset clears every configuration bit and both flip-flops, so that out_x, out_y and cfg_dout are 0 after reset.
- R2: While cfg_en is high, each rising clock edge shifts cfg_din into the 48-bit chain. Bits are taken least significant first in this order: F table (chain bits 0-15), G table (16-31), H table (32-39), then the 8 selection bits (40-47). cfg_dout presents chain bit 0, so after a load the bits leave in the order they were sent.
- R3: While cfg_en is low, cfg_din has no effect: cfg_dout and the outputs are unchanged by it.
- R4: Each 4-input table outputs the truth-table bit whose index is its input word, with input 0 as the least significant address bit. The same rule applies to H, with index {h2,h1,h0}.
- R5: Selection bit 0 set makes H input 0 come from h_aux0 instead of F. Selection bit 1 set makes H input 1 come from h_aux1 instead of G. H input 2 is always h_dir2.
- R6: With H used as a 2:1 multiplexer steered by h_dir2, the tile produces any 5-input function of the shared table inputs and h_dir2.
- R7: Selection bits 3:2 (X) and 5:4 (Y) choose the flip-flop source: 0 = F, 1 = G, 2 or 3 = H. While cfg_en is low, each flip-flop captures its source on every rising edge.
- R8: While cfg_en is high, both flip-flops hold their value.
- R9: Selection bit 6 (X) and bit 7 (Y) set drive the output from the flip-flop. When the bit is clear, the output follows the selected source without a clock edge.
- R10: With F, G and H loaded with parity tables, the tile gives the parity of all nine inputs f_in, g_in and h_dir2.
- R11: With F and G loaded as 2-bit equality compares and H as a 3-input AND, the tile gives a 4-bit equality result that is cascaded through h_dir2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (chain bit 0) |
| f_in | input | 4 | F table inputs, bit 0 is the address LSB |
| g_in | input | 4 | G table inputs, bit 0 is the address LSB |
| h_aux0 | input | 1 | Direct alternative for H input 0 |
| h_aux1 | input | 1 | Direct alternative for H input 1 |
| h_dir2 | input | 1 | H input 2 |
| out_x | output | 1 | X output, registered or combinational |
| out_y | output | 1 | Y output, registered or combinational |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before any check counts. They also assume that all inputs change only between clock edges, so that the value captured at an edge is the one present through the cycle before it. The bench drives every input on the falling edge and samples shortly after it. It leaves cfg_en low whenever register capture is being checked. The outputs are judged only after a complete 48-bit load, since they are not meaningful while the chain is shifting.

// File: rtl/tile_pkg.sv
`timescale 1ns/1ps
// Shared types for the logic tile.
// Assumes: selection byte layout below is fixed; consumers decode it by field.
package tile_pkg;
    localparam int H_K = 3;

    typedef enum logic [1:0] {
        SRC_F     = 2'd0,
        SRC_G     = 2'd1,
        SRC_H     = 2'd2,
        SRC_H_ALT = 2'd3
    } src_e;

    // Packed MSB first: bit 7 y_reg ... bit 0 h0_direct.
    typedef struct packed {
        logic y_reg;
        logic x_reg;
        src_e y_src;
        src_e x_src;
        logic h1_direct;
        logic h0_direct;
    } sel_t;

    localparam int SEL_W = $bits(sel_t);
endpackage

// File: rtl/tile_lut.sv
`timescale 1ns/1ps
// Truth-table lookup of K inputs.
// Assumes: table_bits bit i is the result for address i; addr bit 0 is the LSB.
module tile_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      addr,
    output logic              y
);
    // Pick the stored bit addressed by the inputs.
    always_comb y = table_bits[addr];
endmodule

// File: rtl/tile_cfg_chain.sv
`timescale 1ns/1ps
// Serial configuration shift register.
// Assumes: first bit sent ends at bit 0 after LEN shifts.
module tile_cfg_chain #(
    parameter int LEN = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] bits,
    output logic           dout
);
    // Shift toward bit 0 while enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        bits <= '0;
        else if (shift_en) bits <= {din, bits[LEN-1:1]};
    end

    always_comb dout = bits[0];

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> bits[LEN-1] == $past(din));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(bits));
    a_r1_chain_clear: assert property (@(posedge clk)
        !rst_n |=> bits == '0);
endmodule

// File: rtl/tile_out_stage.sv
`timescale 1ns/1ps
// One tile output: source select, flip-flop and registered/combinational pick.
// Assumes: hold is high during configuration load.
module tile_out_stage
    import tile_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  src_e src,
    input  logic use_reg,
    input  logic f,
    input  logic g,
    input  logic h,
    output logic o
);
    logic d;
    logic q;

    // Choose the flip-flop source from the three tables.
    always_comb begin
        unique case (src)
            SRC_F:   d = f;
            SRC_G:   d = g;
            default: d = h;
        endcase
    end

    // Capture the source unless configuration is loading.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (!hold) q <= d;
    end

    // Drive either the stored or the live value.
    always_comb o = use_reg ? q : d;

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> q == $past(d));
    a_r8_hold_during_load: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q));
    a_r1_flop_clear: assert property (@(posedge clk)
        !rst_n |=> q == 1'b0);
endmodule

// File: rtl/logic_tile.sv
`timescale 1ns/1ps
// Configurable logic tile: F and G tables feed an H table; two output stages.
// Assumes: configuration is shifted in fully before outputs are used.
module logic_tile
    import tile_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    output logic             cfg_dout,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_aux0,
    input  logic             h_aux1,
    input  logic             h_dir2,
    output logic             out_x,
    output logic             out_y
);
    localparam int LUT_BITS = 1 << LUT_K;
    localparam int H_BITS   = 1 << H_K;
    localparam int H_BASE   = 2 * LUT_BITS;
    localparam int SEL_BASE = H_BASE + H_BITS;
    localparam int CHAIN_W  = SEL_BASE + SEL_W;

    logic [CHAIN_W-1:0] chain;
    sel_t               sel;
    logic [LUT_K-1:0]   lut_addr [2];
    logic [1:0]         lut_out;
    logic [H_K-1:0]     h_addr;
    logic               h_out;
    src_e               out_src  [2];
    logic [1:0]         out_reg;
    logic [1:0]         out_val;

    tile_cfg_chain #(.LEN(CHAIN_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(cfg_en), .din(cfg_din),
        .bits(chain), .dout(cfg_dout)
    );

    // Decode the selection field from the chain tail.
    always_comb sel = sel_t'(chain[SEL_BASE +: SEL_W]);

    always_comb begin
        lut_addr[0] = f_in;
        lut_addr[1] = g_in;
    end

    // F (index 0) and G (index 1) tables.
    for (genvar i = 0; i < 2; i++) begin : g_lut
        tile_lut #(.K(LUT_K)) u_lut (
            .table_bits(chain[i*LUT_BITS +: LUT_BITS]),
            .addr(lut_addr[i]),
            .y(lut_out[i])
        );
    end

    // Steer H inputs from the tables or the direct inputs.
    always_comb begin
        h_addr[0] = sel.h0_direct ? h_aux0 : lut_out[0];
        h_addr[1] = sel.h1_direct ? h_aux1 : lut_out[1];
        h_addr[2] = h_dir2;
    end

    tile_lut #(.K(H_K)) u_hlut (
        .table_bits(chain[H_BASE +: H_BITS]),
        .addr(h_addr),
        .y(h_out)
    );

    always_comb begin
        out_src[0] = sel.x_src;
        out_src[1] = sel.y_src;
        out_reg    = {sel.y_reg, sel.x_reg};
    end

    // X (index 0) and Y (index 1) output stages.
    for (genvar j = 0; j < 2; j++) begin : g_out
        tile_out_stage u_stage (
            .clk(clk), .rst_n(rst_n), .hold(cfg_en),
            .src(out_src[j]), .use_reg(out_reg[j]),
            .f(lut_out[0]), .g(lut_out[1]), .h(h_out),
            .o(out_val[j])
        );
    end

    always_comb begin
        out_x = out_val[0];
        out_y = out_val[1];
    end

    a_r5_h2_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && sel.h0_direct && sel.h1_direct && sel.x_src == SRC_H && !sel.x_reg)
        |-> out_x == chain[H_BASE + {h_dir2, h_aux1, h_aux0}]);
    a_r3_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_dout));
endmodule

// File: tb/logic_tile_test.sv
`timescale 1ns/1ps
module logic_tile_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic cfg_dout;
    logic [3:0] f_in = '0;
    logic [3:0] g_in = '0;
    logic h_aux0 = 1'b0, h_aux1 = 1'b0, h_dir2 = 1'b0;
    logic out_x, out_y;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    logic_tile uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .f_in(f_in), .g_in(g_in), .h_aux0(h_aux0),
        .h_aux1(h_aux1), .h_dir2(h_dir2), .out_x(out_x), .out_y(out_y)
    );

    // Words are {sel, H, G, F}.
    localparam logic [47:0] W_PAR = {8'h08, 8'h96, 16'h6996, 16'h6996};
    localparam logic [47:0] W_EQ  = {8'h18, 8'h80, 16'h8421, 16'h8421};
    localparam logic [47:0] W_MUX = {8'h08, 8'hCA, 16'hFFFE, 16'h8000};
    localparam logic [47:0] W_AUX = {8'h0B, 8'hCA, 16'hFFFE, 16'h8000};
    localparam logic [47:0] W_REG = {8'hE0, 8'h55, 16'hAAAA, 16'hAAAA};
    localparam logic [47:0] W_CMB = {8'hA0, 8'h55, 16'hAAAA, 16'hAAAA};

    // {f_in, g_in, h_dir2, expected x (9-bit parity), expected y (f parity)}
    localparam logic [10:0] VEC [8] = '{
        {4'h0, 4'h0, 1'b0, 1'b0, 1'b0},
        {4'h1, 4'h0, 1'b0, 1'b1, 1'b1},
        {4'hF, 4'hF, 1'b1, 1'b1, 1'b0},
        {4'hA, 4'h3, 1'b0, 1'b0, 1'b0},
        {4'h7, 4'h0, 1'b1, 1'b0, 1'b1},
        {4'h8, 4'h1, 1'b1, 1'b1, 1'b1},
        {4'hE, 4'h5, 1'b0, 1'b1, 1'b1},
        {4'h0, 4'hC, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Called on a falling edge; returns on a falling edge with cfg_en low.
    task automatic load_cfg(input logic [47:0] w);
        for (int i = 0; i < 48; i++) begin
            cfg_en = 1'b1;
            cfg_din = w[i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic held;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 out_x", out_x, 1'b0);
        chk("R1 out_y", out_y, 1'b0);
        chk("R1 cfg_dout", cfg_dout, 1'b0);
        @(negedge clk);

        // R10/R4 parity vectors, combinational outputs
        load_cfg(W_PAR);
        for (int v = 0; v < 8; v++) begin
            {f_in, g_in, h_dir2} = VEC[v][10:2];
            #1;
            chk("R10 nine-input parity", out_x, VEC[v][1]);
            chk("R4 F lookup", out_y, VEC[v][0]);
        end
        @(negedge clk);

        // R11 cascaded equality
        load_cfg(W_EQ);
        f_in = 4'b1001; g_in = 4'b1111; h_dir2 = 1'b1; #1;
        chk("R11 low pair differs", out_x, 1'b0);
        f_in = 4'b0101; #1;
        chk("R11 all equal", out_x, 1'b1);
        h_dir2 = 1'b0; #1;
        chk("R11 cascade in low", out_x, 1'b0);
        h_dir2 = 1'b1; g_in = 4'b0111; #1;
        chk("R11 high pair differs", out_x, 1'b0);
        chk("R4 G lookup", out_y, 1'b0);
        @(negedge clk);

        // R2 readback: bits leave in the order sent
        chk("R2 readback bit0", cfg_dout, W_EQ[0]);
        for (int i = 1; i < 48; i++) begin
            cfg_en = 1'b1; cfg_din = 1'b0;
            @(negedge clk);
            chk("R2 readback", cfg_dout, W_EQ[i]);
        end
        cfg_en = 1'b0;

        // R3 cfg_din ignored while idle
        held = cfg_dout;
        for (int i = 0; i < 4; i++) begin
            cfg_din = ~cfg_din;
            @(negedge clk);
            chk("R3 dout unchanged", cfg_dout, held);
        end
        cfg_din = 1'b0;

        // R6 five-input function: e ? OR4 : AND4
        load_cfg(W_MUX);
        f_in = 4'b0111; g_in = 4'b0111; h_dir2 = 1'b0; #1;
        chk("R6 and4 branch", out_x, 1'b0);
        h_dir2 = 1'b1; #1;
        chk("R6 or4 branch", out_x, 1'b1);
        f_in = 4'b1111; g_in = 4'b1111; h_dir2 = 1'b0; #1;
        chk("R6 and4 true", out_x, 1'b1);
        f_in = 4'b0000; g_in = 4'b0000; h_dir2 = 1'b1; #1;
        chk("R6 or4 false", out_x, 1'b0);
        @(negedge clk);

        // R5 direct H inputs
        load_cfg(W_AUX);
        f_in = 4'hF; g_in = 4'h0; h_aux0 = 1'b0; h_aux1 = 1'b1; h_dir2 = 1'b0; #1;
        chk("R5 aux0 replaces F", out_x, 1'b0);
        h_dir2 = 1'b1; #1;
        chk("R5 aux1 replaces G", out_x, 1'b1);
        h_aux0 = 1'b1; h_aux1 = 1'b0; h_dir2 = 1'b0; #1;
        chk("R5 aux0 high", out_x, 1'b1);
        @(negedge clk);

        // R7/R9 registered outputs: x = F reg, y = H (not F) reg
        load_cfg(W_REG);
        f_in = 4'h0;
        @(negedge clk);
        chk("R7 x captures F", out_x, 1'b0);
        chk("R7 y captures H", out_y, 1'b1);
        f_in = 4'h1; #1;
        chk("R9 registered x waits", out_x, 1'b0);
        @(negedge clk);
        chk("R7 x after edge", out_x, 1'b1);
        chk("R7 y after edge", out_y, 1'b0);

        // R8 flops hold through a full load
        f_in = 4'h0;
        load_cfg(W_REG);
        #1;
        chk("R8 x held", out_x, 1'b1);
        chk("R8 y held", out_y, 1'b0);
        @(negedge clk);
        chk("R7 x resumes", out_x, 1'b0);
        chk("R7 y resumes", out_y, 1'b1);

        // R1 reset clears a loaded tile
        f_in = 4'h1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; #1;
        chk("R1 x cleared", out_x, 1'b0);
        chk("R1 dout cleared", cfg_dout, 1'b0);

        // R9 combinational x follows F at once
        load_cfg(W_CMB);
        f_in = 4'h1; #1;
        chk("R9 comb x high", out_x, 1'b1);
        f_in = 4'h0; #1;
        chk("R9 comb x low", out_x, 1'b0);

        finish_run();
    end
endmodule